// File: doc/BRIEF.md
# Tag command frame serializer

This block turns one downlink command for a low-frequency tag into a stream of symbols for a symbol transmitter. A single start strobe captures a packed control byte together with a 32-bit password, 32-bit data and a 3-bit block address. The block assembles the whole command frame into a register in one step. It then hands the frame to the transmitter one symbol at a time through a valid/ready handshake.

Four downlink modes are supported. The fixed mode and the long-reference mode carry one bit per symbol. The long-reference mode also sends a flagged reference symbol before the first frame bit. The leading-zero mode carries one bit per symbol and puts reference and padding zeros into the frame. The one-of-four mode packs two frame bits into each symbol, so fields straddle symbol boundaries. A busy output covers the whole transfer. Waiting for tag programming and reading the tag's reply are left to other logic.

Top module: `tag_frame_serializer`

## Requirements
- R1: After reset, busy_o and sym_valid_o are low.
- R2: In fixed mode (mode code 0), the frame is sent one bit per symbol in sym_bits_o[0], with sym_bits_o[1]=0 and sym_pair_o=0. The frame is: the opcode, then the 32-bit password if password mode is set, then a lock bit of 0, then the 32 data bits unless read command is set, then the 3 address bits unless regular read is set. Every field goes MSB first. The frame is never longer than 80 bits.
- R3: The opcode is 1 followed by the page bit, or 0 followed by 1 when test mode is set.
- R4: In leading-zero mode (mode code 2), one 0 bit comes before the opcode. When password mode is set, two 0 bits come before the password.
- R5: In one-of-four mode (mode code 3), two 0 bits come before the opcode, and two 0 bits come before the password when password mode is set. Consecutive bits are sent in pairs with sym_pair_o=1, and the earlier bit is placed in sym_bits_o[1].
- R6: In one-of-four mode, a frame of odd length ends with a symbol whose low bit sym_bits_o[0] is 0.
- R7: In long-reference mode (mode code 1), the first symbol has sym_longref_o=1 and sym_bits_o=0. The fixed-mode frame follows it. sym_longref_o is 0 on every other symbol.
- R8: busy_o rises on the clock after an accepted start strobe. It stays high until the clock edge at which the last symbol is accepted, and then falls.
- R9: A start strobe while busy_o is high is ignored. The running frame goes on unchanged, and no frame is queued.
- R10: While sym_valid_o is high and sym_ready_i is low, sym_valid_o, sym_bits_o, sym_pair_o and sym_longref_o hold their values. A symbol is consumed only on a cycle where sym_valid_o and sym_ready_i are both high.
- R11: The control byte ctrl_i is decoded as follows: bit 0 is password mode, bit 1 is page, bit 2 is test mode, bits 4:3 are the downlink mode code, bit 5 is regular read, and bit 6 is read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe that captures a command |
| ctrl_i | input | 7 | Packed command control byte |
| pwd_i | input | 32 | Password |
| data_i | input | 32 | Block data for write commands |
| addr_i | input | 3 | Block address |
| sym_ready_i | input | 1 | Transmitter accepts the current symbol |
| sym_valid_o | output | 1 | A symbol is offered |
| sym_bits_o | output | 2 | Symbol value (bit 0 only, unless sym_pair_o is high) |
| sym_pair_o | output | 1 | Symbol carries two frame bits |
| sym_longref_o | output | 1 | Symbol is the long reference pulse |
| busy_o | output | 1 | A frame is in progress |

## Verification
The bench uses one-of-four frames of odd length: the shortest read, and a regular read with a password. These catch a design that drops the last bit or pads it with garbage instead of a zero. Every mode is sent with and without a password, because a design that misplaces the two padding zeros shifts the password and every field after it by two bits. A second start strobe is issued in the middle of a frame. A design that reloads on it would corrupt the symbol stream or lengthen busy. Random and long back-pressure stalls expose symbols that change or advance while not accepted. Long-reference frames catch a reference symbol that is missing, carries non-zero bits, or replaces the first opcode bit.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  parameter int PWD_W  = 32;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 3;
  parameter int CTRL_W = 7;

  typedef enum logic [1:0] {
    DL_FIXED    = 2'd0,
    DL_LONGREF  = 2'd1,
    DL_LEADZERO = 2'd2,
    DL_QUAD     = 2'd3
  } dl_mode_e;

  typedef struct packed {
    logic     use_pwd;
    logic     page;
    logic     test;
    dl_mode_e mode;
    logic     regular_read;
    logic     read_cmd;
  } cmd_flags_t;

  // Field positions of the packed control byte (R11)
  function automatic cmd_flags_t decode_ctrl(input logic [CTRL_W-1:0] c);
    cmd_flags_t f;
    f.use_pwd      = c[0];
    f.page         = c[1];
    f.test         = c[2];
    f.mode         = dl_mode_e'(c[4:3]);
    f.regular_read = c[5];
    f.read_cmd     = c[6];
    return f;
  endfunction

endpackage

// File: rtl/tfs_frame_builder.sv
module tfs_frame_builder
  import tfs_pkg::*;
#(
  parameter int FRAME_W = 80,
  localparam int LEN_W  = $clog2(FRAME_W + 1)
) (
  input  cmd_flags_t          cmd_i,
  input  logic [PWD_W-1:0]    pwd_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [LEN_W-1:0]    len_o
);

  logic [FRAME_W-1:0] acc;
  logic [LEN_W-1:0]   n;
  logic [1:0]         opcode;
  logic               zero_pad;

  always_comb begin
    acc      = '0;
    n        = '0;
    zero_pad = (cmd_i.mode == DL_LEADZERO) || (cmd_i.mode == DL_QUAD);
    opcode   = cmd_i.test ? 2'b01 : {1'b1, cmd_i.page};

    // reference zeros ahead of the opcode
    if (zero_pad) begin
      acc = acc << 1;
      n   = n + LEN_W'(1);
    end
    if (cmd_i.mode == DL_QUAD) begin
      acc = acc << 1;
      n   = n + LEN_W'(1);
    end

    acc = (acc << 2) | FRAME_W'(opcode);
    n   = n + LEN_W'(2);

    if (cmd_i.use_pwd) begin
      if (zero_pad) begin
        acc = acc << 2;
        n   = n + LEN_W'(2);
      end
      acc = (acc << PWD_W) | FRAME_W'(pwd_i);
      n   = n + LEN_W'(PWD_W);
    end

    // lock bit, always zero
    acc = acc << 1;
    n   = n + LEN_W'(1);

    if (!cmd_i.read_cmd) begin
      acc = (acc << DATA_W) | FRAME_W'(data_i);
      n   = n + LEN_W'(DATA_W);
    end

    if (!cmd_i.regular_read) begin
      acc = (acc << ADDR_W) | FRAME_W'(addr_i);
      n   = n + LEN_W'(ADDR_W);
    end

    p_frame_fits_r2: assert (n <= LEN_W'(FRAME_W));

    frame_o = acc << (LEN_W'(FRAME_W) - n);
    len_o   = n;
  end

endmodule

// File: rtl/tfs_symbol_shifter.sv
module tfs_symbol_shifter #(
  parameter int FRAME_W = 80,
  localparam int LEN_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               pair_i,
  input  logic               longref_i,
  input  logic               sym_ready_i,
  output logic               sym_valid_o,
  output logic [1:0]         sym_bits_o,
  output logic               sym_pair_o,
  output logic               sym_longref_o,
  output logic               busy_o
);

  logic [FRAME_W-1:0] shreg_q;
  logic [LEN_W-1:0]   rem_q;
  logic               pair_q;
  logic               lr_pend_q;
  logic               busy_q;
  logic               valid_q;
  logic [1:0]         bits_q;
  logic               lr_q;

  logic               take_two;
  logic [LEN_W-1:0]   step;
  logic [1:0]         nxt_bits;
  logic               advance;

  always_comb begin
    take_two = pair_q && (rem_q >= LEN_W'(2));
    step     = take_two ? LEN_W'(2) : LEN_W'(1);
    if (pair_q)
      nxt_bits = {shreg_q[FRAME_W-1], take_two ? shreg_q[FRAME_W-2] : 1'b0};
    else
      nxt_bits = {1'b0, shreg_q[FRAME_W-1]};
    advance  = busy_q && (!valid_q || sym_ready_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q   <= '0;
      rem_q     <= '0;
      pair_q    <= 1'b0;
      lr_pend_q <= 1'b0;
      busy_q    <= 1'b0;
      valid_q   <= 1'b0;
      bits_q    <= 2'b00;
      lr_q      <= 1'b0;
    end else if (load_i) begin
      shreg_q   <= frame_i;
      rem_q     <= len_i;
      pair_q    <= pair_i;
      lr_pend_q <= longref_i;
      busy_q    <= 1'b1;
      valid_q   <= 1'b0;
      lr_q      <= 1'b0;
    end else if (advance) begin
      if (lr_pend_q) begin
        valid_q   <= 1'b1;
        bits_q    <= 2'b00;
        lr_q      <= 1'b1;
        lr_pend_q <= 1'b0;
      end else if (rem_q != '0) begin
        valid_q <= 1'b1;
        bits_q  <= nxt_bits;
        lr_q    <= 1'b0;
        shreg_q <= shreg_q << step;
        rem_q   <= rem_q - step;
      end else begin
        valid_q <= 1'b0;
        busy_q  <= 1'b0;
        lr_q    <= 1'b0;
      end
    end
  end

  assign sym_valid_o   = valid_q;
  assign sym_bits_o    = bits_q;
  assign sym_pair_o    = pair_q;
  assign sym_longref_o = lr_q;
  assign busy_o        = busy_q;

  // R10: an offered symbol holds until taken
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (sym_valid_o && !sym_ready_i) |=> (sym_valid_o && $stable(sym_bits_o)
                                       && $stable(sym_longref_o) && $stable(sym_pair_o)));

  // R8: no symbol offered outside a busy period
  p_valid_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    sym_valid_o |-> busy_o);

  // R7: the reference symbol carries no data
  p_longref_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (sym_valid_o && sym_longref_o) |-> (sym_bits_o == 2'b00 && !sym_pair_o));

  // R2: single-bit symbols leave the high bit clear
  p_single_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (sym_valid_o && !sym_pair_o) |-> (sym_bits_o[1] == 1'b0));

endmodule

// File: rtl/tag_frame_serializer.sv
module tag_frame_serializer
  import tfs_pkg::*;
#(
  parameter int FRAME_W = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [PWD_W-1:0]  pwd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sym_ready_i,
  output logic              sym_valid_o,
  output logic [1:0]        sym_bits_o,
  output logic              sym_pair_o,
  output logic              sym_longref_o,
  output logic              busy_o
);

  localparam int LEN_W = $clog2(FRAME_W + 1);

  cmd_flags_t         cmd;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;
  logic               start_acc;

  assign cmd       = decode_ctrl(ctrl_i);
  assign start_acc = start_i && !busy_o;

  tfs_frame_builder #(.FRAME_W(FRAME_W)) u_build (
    .cmd_i   (cmd),
    .pwd_i   (pwd_i),
    .data_i  (data_i),
    .addr_i  (addr_i),
    .frame_o (frame),
    .len_o   (frame_len)
  );

  tfs_symbol_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk           (clk),
    .rst           (rst),
    .load_i        (start_acc),
    .frame_i       (frame),
    .len_i         (frame_len),
    .pair_i        (cmd.mode == DL_QUAD),
    .longref_i     (cmd.mode == DL_LONGREF),
    .sym_ready_i   (sym_ready_i),
    .sym_valid_o   (sym_valid_o),
    .sym_bits_o    (sym_bits_o),
    .sym_pair_o    (sym_pair_o),
    .sym_longref_o (sym_longref_o),
    .busy_o        (busy_o)
  );

  // R8: busy only rises after a start strobe
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R9: a strobe during a frame neither ends nor restarts it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !(sym_valid_o && sym_ready_i)) |=> busy_o);

endmodule

// File: tb/tb_tag_frame_serializer.sv
module tb_tag_frame_serializer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [6:0]  ctrl_i = '0;
  logic [31:0] pwd_i = '0;
  logic [31:0] data_i = '0;
  logic [2:0]  addr_i = '0;
  logic        sym_ready_i = 1'b0;
  logic        sym_valid_o;
  logic [1:0]  sym_bits_o;
  logic        sym_pair_o;
  logic        sym_longref_o;
  logic        busy_o;

  always #4 clk = ~clk;

  tag_frame_serializer dut (
    .clk(clk), .rst(rst), .start_i(start_i), .ctrl_i(ctrl_i),
    .pwd_i(pwd_i), .data_i(data_i), .addr_i(addr_i),
    .sym_ready_i(sym_ready_i), .sym_valid_o(sym_valid_o),
    .sym_bits_o(sym_bits_o), .sym_pair_o(sym_pair_o),
    .sym_longref_o(sym_longref_o), .busy_o(busy_o)
  );

  int    checks = 0;
  int    fails  = 0;
  int    exp_q[$];          // each entry = {longref, pair, bits[1:0]}
  bit    exp_busy = 1'b0;
  string cur_req = "R2";
  int    rdy_mode = 0;      // 0 random, 1 always, 2 long stalls
  int    cyc = 0;
  bit    timed_out = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference frame built directly from the requirements (R2..R7, R11)
  task automatic model_frame(input logic [6:0] c, input logic [31:0] pw,
                             input logic [31:0] dt, input logic [2:0] ad);
    bit q[$];
    int mode = int'(c[4:3]);
    if (mode == 2) q.push_back(1'b0);                        // R4
    if (mode == 3) begin q.push_back(1'b0); q.push_back(1'b0); end // R5
    if (c[2]) begin q.push_back(1'b0); q.push_back(1'b1); end      // R3
    else begin q.push_back(1'b1); q.push_back(c[1]); end
    if (c[0]) begin
      if (mode >= 2) begin q.push_back(1'b0); q.push_back(1'b0); end
      for (int i = 31; i >= 0; i--) q.push_back(pw[i]);
    end
    q.push_back(1'b0);
    if (!c[6]) for (int i = 31; i >= 0; i--) q.push_back(dt[i]);
    if (!c[5]) for (int i = 2; i >= 0; i--) q.push_back(ad[i]);
    if (mode == 1) exp_q.push_back(8);                       // R7
    if (mode == 3) begin
      for (int i = 0; i < q.size(); i += 2) begin
        int lo = (i + 1 < q.size()) ? int'(q[i+1]) : 0;      // R6
        exp_q.push_back(4 + 2 * int'(q[i]) + lo);
      end
    end else begin
      foreach (q[i]) exp_q.push_back(int'(q[i]));
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      int act;
      bit hs;
      cyc++;
      check(busy_o == exp_busy, "R8", int'(busy_o), int'(exp_busy), "busy");
      act = {sym_longref_o, sym_pair_o, sym_bits_o};
      if (sym_valid_o) begin
        if (exp_q.size() == 0)
          check(1'b0, cur_req, act, 0, "unexpected symbol");
        else
          check(act == exp_q[0], cur_req, act, exp_q[0], "symbol");
      end
      case (rdy_mode)
        1:       sym_ready_i = 1'b1;
        2:       sym_ready_i = ($urandom_range(0, 5) == 0);
        default: sym_ready_i = ($urandom_range(0, 2) != 0);
      endcase
      hs = sym_valid_o && sym_ready_i;
      if (hs && exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        if (exp_q.size() == 0) exp_busy = 1'b0;
      end
      if (start_i && !exp_busy) begin
        model_frame(ctrl_i, pwd_i, data_i, addr_i);
        exp_busy = 1'b1;
      end
    end
  end

  task automatic send(input logic [6:0] c, input logic [31:0] pw, input logic [31:0] dt,
                      input logic [2:0] ad, input string req);
    @(posedge clk); #1;
    if (!exp_busy) cur_req = req;
    ctrl_i = c; pwd_i = pw; data_i = dt; addr_i = ad; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while ((exp_busy || exp_q.size() != 0) && n < 4000) begin
      @(posedge clk);
      n++;
    end
    @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0, "symbols left over");
    check(!busy_o, req, int'(busy_o), 0, "busy after frame");
  endtask

  // control byte: bit0 pwd, bit1 page, bit2 test, [4:3] mode, bit5 regread, bit6 read (R11)
  function automatic logic [6:0] mk(input bit pw, input bit pg, input bit tst,
                                     input int mode, input bit rr, input bit rd);
    return {rd, rr, 2'(mode), tst, pg, pw};
  endfunction

  initial begin
    void'($urandom(7));
    repeat (4) @(posedge clk);
    #1;
    check(!busy_o, "R1", int'(busy_o), 0, "busy in reset");
    check(!sym_valid_o, "R1", int'(sym_valid_o), 0, "valid in reset");
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !sym_valid_o, "R1", int'({busy_o, sym_valid_o}), 0, "idle after reset");

    rdy_mode = 1;
    send(mk(0,0,0,0,0,0), 32'h0, 32'hA5C3_0F81, 3'd5, "R2");            wait_idle("R2");
    rdy_mode = 0;
    send(mk(1,1,0,0,0,0), 32'hDEAD_BEEF, 32'h1234_5678, 3'd2, "R2");    wait_idle("R2");
    send(mk(0,1,0,0,1,1), 32'h0, 32'h0, 3'd7, "R2");                    wait_idle("R2");
    send(mk(0,1,1,0,0,0), 32'h0, 32'hFFFF_0000, 3'd1, "R3");            wait_idle("R3");
    send(mk(1,0,0,2,0,0), 32'h8000_0001, 32'h0F0F_F0F0, 3'd6, "R4");    wait_idle("R4");
    send(mk(0,0,0,2,0,1), 32'h0, 32'h0, 3'd3, "R4");                    wait_idle("R4");
    send(mk(1,1,0,3,0,0), 32'hC001_D00D, 32'h9ABC_DEF0, 3'd4, "R5");    wait_idle("R5");
    send(mk(1,0,0,3,0,1), 32'h5555_AAAA, 32'h0, 3'd5, "R5");            wait_idle("R5");
    send(mk(0,1,0,3,1,1), 32'h0, 32'h0, 3'd0, "R6");                    wait_idle("R6");
    send(mk(1,0,1,3,1,1), 32'hFFFF_FFFF, 32'h0, 3'd0, "R6");            wait_idle("R6");
    send(mk(0,0,0,3,1,0), 32'h0, 32'h7654_3211, 3'd0, "R6");            wait_idle("R6");
    send(mk(1,0,0,1,0,0), 32'h0BAD_F00D, 32'h3C3C_C3C3, 3'd3, "R7");    wait_idle("R7");
    send(mk(0,1,0,1,0,1), 32'h0, 32'h0, 3'd6, "R7");                    wait_idle("R7");
    rdy_mode = 2;
    send(mk(1,1,0,3,0,0), 32'h1357_9BDF, 32'h2468_ACE0, 3'd7, "R10");   wait_idle("R10");
    send(mk(0,0,0,1,0,0), 32'h0, 32'hF00F_0FF0, 3'd1, "R10");           wait_idle("R10");
    rdy_mode = 0;
    send(mk(0,0,0,0,0,0), 32'h0, 32'h8421_8421, 3'd2, "R9");
    repeat (3) @(posedge clk);
    send(mk(1,1,1,3,1,1), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, "R9");    // ignored while busy
    wait_idle("R9");
    send(mk(1,1,0,2,1,0), 32'h0F1E_2D3C, 32'h4B5A_6978, 3'd0, "R11");   wait_idle("R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    timed_out = 1'b1;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule